// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block carries 32-bit command verbs from a circular command ring in memory to the attached audio codecs. It also writes every codec reply into a circular response ring. Software fills ring slots and then advances the command write pointer. The engine pre-increments its 8-bit read pointer, fetches the slot and offers the verb on a valid/ready link. When a reply comes back, the engine pre-increments the response write pointer and stores an 8-byte entry. The entry holds the reply word, then an extended word that carries the codec address and a flag marking unsolicited replies.

Command fetching is throttled by a reply counter. Once the counter reaches a programmed threshold, no further verb is fetched until software clears the response interrupt flag. Clearing the flag also zeroes the counter. A separate immediate path lets software send a single verb without using the rings. It has a command word, a captured reply word and a status register. The immediate verb takes precedence over ring fetches.

Ring memory is reached through a synchronous read port and a single-cycle write port. Software reaches the registers through a simple indexed write strobe and a combinational read port.

Top module: `ccr_engine`

## Requirements
- R1: After reset, the command read pointer (register 1) reads 0. The response write pointer (register 3), the response status (register 6) and the immediate status (register 9) also read 0. No verb is offered and the interrupt output is low.
- R2: A command is fetched only under three conditions: the run bit (register 2, bit 0) is 1, the read pointer differs from the write pointer (register 0), and the reply counter differs from the threshold (register 4).
- R3: Before each fetch, the read pointer increments modulo 256. The slot is read at command ring base + 4 × pointer, and verbs leave in ring order, across the wrap from 255 to 0.
- R4: A verb with bit 27 set is never offered on the link. This holds for a verb fetched from the ring and for the immediate command. A ring pointer still advances past such a verb, and the immediate busy bit stays set.
- R5: While a verb is offered and not accepted, valid stays high and the verb data stays stable.
- R6: An armed immediate command (register 7, armed by writing 1 to register 9 bit 0) is sent before any further ring fetch.
- R7: A reply that arrives while immediate busy is set does four things: it is stored in register 8, it clears busy (bit 0), it sets valid (bit 1), and it writes the codec address into bits 7:4 of register 9. Such a reply is not written to the response ring.
- R8: Any other reply, when response DMA is on (register 5 bit 1), increments the response write pointer modulo 256 and writes one 64-bit entry at response ring base + 8 × pointer. The low word holds the reply. The high word holds the codec address in bits 3:0 and a 1 in bit 4 for unsolicited replies.
- R9: With response DMA off, a reply that is not captured by the immediate path is dropped: no memory write and no pointer change.
- R10: When interrupts are enabled (register 5 bit 0), a stored reply sets the flag (register 6 bit 0, mirrored on `rsp_irq`) in either of two cases: the reply counter reaches the threshold, or the command ring is empty. When interrupts are disabled, the flag stays 0.
- R11: Writing 1 to register 6 bit 0 while the flag is set clears the flag, zeroes the reply counter and lets fetching resume.
- R12: Writing register 3 with bit 15 set clears the response write pointer.
- R13: Writing 1 to register 9 bit 1 clears the immediate valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register index for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_ring_base | input | AW | Byte base of the command ring |
| rsp_ring_base | input | AW | Byte base of the response ring |
| cmd_mem_rd_en | output | 1 | Command ring read request |
| cmd_mem_addr | output | AW | Command ring read byte address |
| cmd_mem_rdata | input | 32 | Read data, valid the cycle after the request |
| rsp_mem_wr_en | output | 1 | Response ring write strobe |
| rsp_mem_addr | output | AW | Response ring write byte address |
| rsp_mem_wdata | output | 64 | {extended word, reply word} |
| verb_valid | output | 1 | Verb offered to the codec link |
| verb_ready | input | 1 | Codec link accepts the verb |
| verb_data | output | 32 | Verb word |
| rsp_valid | input | 1 | Codec reply present this cycle |
| rsp_word | input | 32 | Codec reply word |
| rsp_cad | input | CAD_W | Address of the replying codec |
| rsp_unsol | input | 1 | Reply is unsolicited |
| rsp_irq | output | 1 | Response interrupt flag |

## Verification
Ring fetching is run with a short burst, with a long run that crosses the 255-to-0 pointer wrap, and with the run bit cleared. These separate correct pointer and address arithmetic from off-by-one or unwrapped pointers, and show that the run gate actually holds fetches back. A slot with bit 27 set, placed between normal slots, shows whether the engine drops only that verb while the pointer still advances. A link stalled with ready low checks that the offered verb holds. An immediate command armed during the stall checks that the immediate path overtakes the pending ring slot.

Replies are sent in several forms: solicited and unsolicited, with DMA on and off, with interrupts on and off, with the command ring non-empty and empty, and while immediate busy is set. These separate the two interrupt triggers (counter and empty ring) from each other, and show that capture into the immediate registers keeps the reply out of the ring.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the codec command/response ring engine.
// Assumes 32-bit verbs and 32-bit register data.
package ccr_pkg;
    localparam int VERB_W       = 32;
    localparam int REG_W        = 32;
    localparam int REG_AW       = 4;
    localparam int INDIRECT_BIT = 27;
    localparam int WP_CLR_BIT   = 15;

    // Register indices
    localparam logic [REG_AW-1:0] RG_CMD_WP  = 4'd0;
    localparam logic [REG_AW-1:0] RG_CMD_RP  = 4'd1;
    localparam logic [REG_AW-1:0] RG_CMD_CTL = 4'd2;
    localparam logic [REG_AW-1:0] RG_RSP_WP  = 4'd3;
    localparam logic [REG_AW-1:0] RG_RSP_THR = 4'd4;
    localparam logic [REG_AW-1:0] RG_RSP_CTL = 4'd5;
    localparam logic [REG_AW-1:0] RG_RSP_STS = 4'd6;
    localparam logic [REG_AW-1:0] RG_IMM_CMD = 4'd7;
    localparam logic [REG_AW-1:0] RG_IMM_RSP = 4'd8;
    localparam logic [REG_AW-1:0] RG_IMM_STS = 4'd9;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_SEND = 2'd2
    } fetch_st_e;

    // True when a verb asks for the unsupported indirect node form.
    function automatic logic verb_is_indirect(input logic [VERB_W-1:0] v);
        return v[INDIRECT_BIT];
    endfunction
endpackage

// File: rtl/ccr_imm_ctrl.sv
`timescale 1ns/1ps
// Immediate command status: busy/pending/valid flags, captured reply and codec address.
// Assumes a reply seen while busy belongs to the immediate command.
module ccr_imm_ctrl #(
    parameter int CAD_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      valid_clr,
    input  logic                      take,
    input  logic                      rsp_valid,
    input  logic [ccr_pkg::VERB_W-1:0] rsp_word,
    input  logic [CAD_W-1:0]          rsp_cad,
    output logic                      capture,
    output logic                      busy,
    output logic                      pending,
    output logic                      valid,
    output logic [CAD_W-1:0]          cad,
    output logic [ccr_pkg::VERB_W-1:0] word
);
    // Reply is captured whenever busy is set.
    assign capture = rsp_valid && busy;

    // Flag and capture registers; capture has final say.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pending <= 1'b0;
            valid   <= 1'b0;
            cad     <= '0;
            word    <= '0;
        end else begin
            if (take) pending <= 1'b0;
            if (arm) begin
                busy    <= 1'b1;
                pending <= 1'b1;
            end
            if (valid_clr) valid <= 1'b0;
            if (capture) begin
                busy    <= 1'b0;
                pending <= 1'b0;
                valid   <= 1'b1;
                cad     <= rsp_cad;
                word    <= rsp_word;
            end
        end
    end
endmodule

// File: rtl/ccr_cmd_fetch.sv
`timescale 1ns/1ps
// Command side: read pointer, ring slot fetch and verb hand-off on valid/ready.
// Assumes ring memory returns read data one cycle after the request.
module ccr_cmd_fetch #(
    parameter int PTR_W = 8,
    parameter int AW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [PTR_W-1:0]           wp,
    input  logic                       fetch_ok,
    input  logic                       imm_pending,
    input  logic [ccr_pkg::VERB_W-1:0] imm_word,
    input  logic [AW-1:0]              ring_base,
    input  logic [ccr_pkg::VERB_W-1:0] mem_rdata,
    input  logic                       verb_ready,
    output logic [PTR_W-1:0]           rp,
    output logic                       imm_take,
    output logic                       mem_rd_en,
    output logic [AW-1:0]              mem_addr,
    output logic                       verb_valid,
    output logic [ccr_pkg::VERB_W-1:0] verb_data
);
    import ccr_pkg::*;

    fetch_st_e          st_q;
    logic [PTR_W-1:0]   rp_q;
    logic [PTR_W-1:0]   rp_nx;
    logic [VERB_W-1:0]  verb_q;

    assign rp_nx      = rp_q + 1'b1;
    assign rp         = rp_q;
    assign verb_valid = (st_q == FS_SEND);
    assign verb_data  = verb_q;
    assign mem_addr   = ring_base + (AW'(rp_nx) << 2);

    // Choose between the immediate verb and a ring fetch while idle.
    always_comb begin
        imm_take  = (st_q == FS_IDLE) && imm_pending;
        mem_rd_en = (st_q == FS_IDLE) && !imm_pending && run &&
                    (rp_q != wp) && fetch_ok;
    end

    // Sequencer: idle -> wait for slot data -> offer verb.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FS_IDLE;
            rp_q   <= '0;
            verb_q <= '0;
        end else begin
            case (st_q)
                FS_IDLE: begin
                    if (imm_take) begin
                        if (!verb_is_indirect(imm_word)) begin
                            verb_q <= imm_word;
                            st_q   <= FS_SEND;
                        end
                    end else if (mem_rd_en) begin
                        rp_q <= rp_nx;
                        st_q <= FS_WAIT;
                    end
                end
                FS_WAIT: begin
                    if (verb_is_indirect(mem_rdata)) begin
                        st_q <= FS_IDLE;
                    end else begin
                        verb_q <= mem_rdata;
                        st_q   <= FS_SEND;
                    end
                end
                FS_SEND: begin
                    if (verb_ready) st_q <= FS_IDLE;
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccr_rsp_store.sv
`timescale 1ns/1ps
// Response side: write pointer, reply counter, interrupt flag and ring entry writes.
// Assumes the ring write port accepts one 64-bit entry per cycle.
module ccr_rsp_store #(
    parameter int PTR_W = 8,
    parameter int AW    = 32,
    parameter int CAD_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rsp_valid,
    input  logic [ccr_pkg::VERB_W-1:0]   rsp_word,
    input  logic [CAD_W-1:0]             rsp_cad,
    input  logic                         rsp_unsol,
    input  logic                         imm_capture,
    input  logic                         dma_en,
    input  logic                         irq_en,
    input  logic [PTR_W-1:0]             thresh,
    input  logic                         ring_empty,
    input  logic                         wp_clr,
    input  logic                         flag_clr,
    input  logic [AW-1:0]                ring_base,
    output logic [PTR_W-1:0]             wp,
    output logic [PTR_W-1:0]             cnt,
    output logic                         flag,
    output logic                         mem_wr_en,
    output logic [AW-1:0]                mem_addr,
    output logic [2*ccr_pkg::VERB_W-1:0] mem_wdata
);
    import ccr_pkg::*;

    logic [PTR_W-1:0]  wp_q;
    logic [PTR_W-1:0]  cnt_q;
    logic              flag_q;
    logic [PTR_W-1:0]  wp_nx;
    logic [PTR_W-1:0]  cnt_base;
    logic [PTR_W-1:0]  cnt_nx;
    logic              store;
    logic              raise;
    logic [VERB_W-1:0] ext_word;

    assign store     = rsp_valid && !imm_capture && dma_en;
    assign wp_nx     = wp_q + 1'b1;
    assign cnt_base  = (flag_clr && flag_q) ? '0 : cnt_q;
    assign cnt_nx    = cnt_base + 1'b1;
    assign raise     = store && irq_en && ((cnt_nx == thresh) || ring_empty);
    assign ext_word  = VERB_W'({rsp_unsol, rsp_cad});

    assign mem_wr_en = store;
    assign mem_addr  = ring_base + (AW'(wp_nx) << 3);
    assign mem_wdata = {ext_word, rsp_word};
    assign wp        = wp_q;
    assign cnt       = cnt_q;
    assign flag      = flag_q;

    // Pointer, counter and flag update; a flag set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wp_clr)     wp_q <= '0;
            else if (store) wp_q <= wp_nx;
            cnt_q <= store ? cnt_nx : cnt_base;
            if (raise)         flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ccr_engine.sv
`timescale 1ns/1ps
// Top of the codec command/response ring engine: owns the software registers
// and wires the fetch, reply-store and immediate units together.
// Assumes one register write per cycle and a combinational register read.
module ccr_engine #(
    parameter int PTR_W = 8,
    parameter int AW    = 32,
    parameter int CAD_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr_en,
    input  logic [ccr_pkg::REG_AW-1:0]    reg_addr,
    input  logic [ccr_pkg::REG_W-1:0]     reg_wdata,
    input  logic [ccr_pkg::REG_AW-1:0]    reg_rd_addr,
    output logic [ccr_pkg::REG_W-1:0]     reg_rdata,
    input  logic [AW-1:0]                 cmd_ring_base,
    input  logic [AW-1:0]                 rsp_ring_base,
    output logic                          cmd_mem_rd_en,
    output logic [AW-1:0]                 cmd_mem_addr,
    input  logic [ccr_pkg::VERB_W-1:0]    cmd_mem_rdata,
    output logic                          rsp_mem_wr_en,
    output logic [AW-1:0]                 rsp_mem_addr,
    output logic [2*ccr_pkg::VERB_W-1:0]  rsp_mem_wdata,
    output logic                          verb_valid,
    input  logic                          verb_ready,
    output logic [ccr_pkg::VERB_W-1:0]    verb_data,
    input  logic                          rsp_valid,
    input  logic [ccr_pkg::VERB_W-1:0]    rsp_word,
    input  logic [CAD_W-1:0]              rsp_cad,
    input  logic                          rsp_unsol,
    output logic                          rsp_irq
);
    import ccr_pkg::*;

    logic [PTR_W-1:0]  cmd_wp_q;
    logic              cmd_run_q;
    logic [PTR_W-1:0]  thr_q;
    logic              irq_en_q;
    logic              dma_en_q;
    logic [VERB_W-1:0] imm_cmd_q;

    logic [PTR_W-1:0]  cmd_rp;
    logic [PTR_W-1:0]  rsp_wp;
    logic [PTR_W-1:0]  rsp_cnt;
    logic              irq_flag;
    logic              imm_take;
    logic              imm_capture;
    logic              imm_busy;
    logic              imm_pending;
    logic              imm_valid;
    logic [CAD_W-1:0]  imm_cad;
    logic [VERB_W-1:0] imm_rsp;

    logic              wp_clr;
    logic              flag_clr;
    logic              imm_arm;
    logic              imm_vclr;

    // Write strobes that act on unit state rather than on a stored field.
    assign wp_clr   = reg_wr_en && (reg_addr == RG_RSP_WP)  && reg_wdata[WP_CLR_BIT];
    assign flag_clr = reg_wr_en && (reg_addr == RG_RSP_STS) && reg_wdata[0];
    assign imm_arm  = reg_wr_en && (reg_addr == RG_IMM_STS) && reg_wdata[0];
    assign imm_vclr = reg_wr_en && (reg_addr == RG_IMM_STS) && reg_wdata[1];
    assign rsp_irq  = irq_flag;

    // Software-owned control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_wp_q  <= '0;
            cmd_run_q <= 1'b0;
            thr_q     <= '0;
            irq_en_q  <= 1'b0;
            dma_en_q  <= 1'b0;
            imm_cmd_q <= '0;
        end else if (reg_wr_en) begin
            case (reg_addr)
                RG_CMD_WP:  cmd_wp_q  <= reg_wdata[PTR_W-1:0];
                RG_CMD_CTL: cmd_run_q <= reg_wdata[0];
                RG_RSP_THR: thr_q     <= reg_wdata[PTR_W-1:0];
                RG_RSP_CTL: begin
                    irq_en_q <= reg_wdata[0];
                    dma_en_q <= reg_wdata[1];
                end
                RG_IMM_CMD: imm_cmd_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Register read-back.
    always_comb begin
        reg_rdata = '0;
        case (reg_rd_addr)
            RG_CMD_WP:  reg_rdata[PTR_W-1:0] = cmd_wp_q;
            RG_CMD_RP:  reg_rdata[PTR_W-1:0] = cmd_rp;
            RG_CMD_CTL: reg_rdata[0]         = cmd_run_q;
            RG_RSP_WP:  reg_rdata[PTR_W-1:0] = rsp_wp;
            RG_RSP_THR: reg_rdata[PTR_W-1:0] = thr_q;
            RG_RSP_CTL: reg_rdata[1:0]       = {dma_en_q, irq_en_q};
            RG_RSP_STS: reg_rdata[0]         = irq_flag;
            RG_IMM_CMD: reg_rdata            = imm_cmd_q;
            RG_IMM_RSP: reg_rdata            = imm_rsp;
            RG_IMM_STS: begin
                reg_rdata[CAD_W+3:4] = imm_cad;
                reg_rdata[1]         = imm_valid;
                reg_rdata[0]         = imm_busy;
            end
            default: ;
        endcase
    end

    ccr_cmd_fetch #(.PTR_W(PTR_W), .AW(AW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cmd_run_q),
        .wp          (cmd_wp_q),
        .fetch_ok    (rsp_cnt != thr_q),
        .imm_pending (imm_pending),
        .imm_word    (imm_cmd_q),
        .ring_base   (cmd_ring_base),
        .mem_rdata   (cmd_mem_rdata),
        .verb_ready  (verb_ready),
        .rp          (cmd_rp),
        .imm_take    (imm_take),
        .mem_rd_en   (cmd_mem_rd_en),
        .mem_addr    (cmd_mem_addr),
        .verb_valid  (verb_valid),
        .verb_data   (verb_data)
    );

    ccr_imm_ctrl #(.CAD_W(CAD_W)) u_imm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (imm_arm),
        .valid_clr (imm_vclr),
        .take      (imm_take),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .rsp_cad   (rsp_cad),
        .capture   (imm_capture),
        .busy      (imm_busy),
        .pending   (imm_pending),
        .valid     (imm_valid),
        .cad       (imm_cad),
        .word      (imm_rsp)
    );

    ccr_rsp_store #(.PTR_W(PTR_W), .AW(AW), .CAD_W(CAD_W)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsp_valid   (rsp_valid),
        .rsp_word    (rsp_word),
        .rsp_cad     (rsp_cad),
        .rsp_unsol   (rsp_unsol),
        .imm_capture (imm_capture),
        .dma_en      (dma_en_q),
        .irq_en      (irq_en_q),
        .thresh      (thr_q),
        .ring_empty  (cmd_rp == cmd_wp_q),
        .wp_clr      (wp_clr),
        .flag_clr    (flag_clr),
        .ring_base   (rsp_ring_base),
        .wp          (rsp_wp),
        .cnt         (rsp_cnt),
        .flag        (irq_flag),
        .mem_wr_en   (rsp_mem_wr_en),
        .mem_addr    (rsp_mem_addr),
        .mem_wdata   (rsp_mem_wdata)
    );
endmodule

// File: rtl/ccr_engine_chk.sv
`timescale 1ns/1ps
// Protocol and pointer checks for ccr_engine, attached by bind.
module ccr_engine_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             verb_valid,
    input logic             verb_ready,
    input logic [31:0]      verb_data,
    input logic             cmd_mem_rd_en,
    input logic             run,
    input logic             rsp_valid,
    input logic             rsp_mem_wr_en,
    input logic             dma_en,
    input logic             imm_busy,
    input logic [PTR_W-1:0] rsp_wp,
    input logic             wp_clr
);
    AST_VERB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        verb_valid && !verb_ready |=> verb_valid && $stable(verb_data)); // R5
    AST_NO_INDIRECT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        verb_valid |-> !verb_data[27]); // R4
    AST_NO_FETCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cmd_mem_rd_en); // R2
    AST_DROP_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !dma_en |-> !rsp_mem_wr_en); // R9
    AST_IMM_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && imm_busy |-> !rsp_mem_wr_en); // R7
    AST_WP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wp_clr |=> rsp_wp == '0); // R12
    AST_RSP_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mem_wr_en && !wp_clr |=> rsp_wp == PTR_W'($past(rsp_wp) + 1'b1)); // R8
endmodule

bind ccr_engine ccr_engine_chk #(.PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .verb_valid    (verb_valid),
    .verb_ready    (verb_ready),
    .verb_data     (verb_data),
    .cmd_mem_rd_en (cmd_mem_rd_en),
    .run           (cmd_run_q),
    .rsp_valid     (rsp_valid),
    .rsp_mem_wr_en (rsp_mem_wr_en),
    .dma_en        (dma_en_q),
    .imm_busy      (imm_busy),
    .rsp_wp        (rsp_wp),
    .wp_clr        (wp_clr)
);

// File: tb/ccr_engine_tb.sv
`timescale 1ns/1ps
// Directed bench for ccr_engine: one task per scenario.
module ccr_engine_tb_top;
    localparam logic [31:0] CMD_BASE = 32'h0000_4000;
    localparam logic [31:0] RSP_BASE = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [31:0] reg_rdata;
    logic        cmd_mem_rd_en;
    logic [31:0] cmd_mem_addr;
    logic [31:0] cmd_mem_rdata = '0;
    logic        rsp_mem_wr_en;
    logic [31:0] rsp_mem_addr;
    logic [63:0] rsp_mem_wdata;
    logic        verb_valid;
    logic        verb_ready = 1'b1;
    logic [31:0] verb_data;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_word = '0;
    logic [3:0]  rsp_cad = '0;
    logic        rsp_unsol = 1'b0;
    logic        rsp_irq;

    logic [31:0] cmd_mem [256];
    logic [63:0] rsp_mem [256];
    logic [31:0] vlog [$];
    int          rsp_wr_cnt = 0;
    logic        addr_err = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    ccr_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .cmd_ring_base(CMD_BASE), .rsp_ring_base(RSP_BASE),
        .cmd_mem_rd_en(cmd_mem_rd_en), .cmd_mem_addr(cmd_mem_addr), .cmd_mem_rdata(cmd_mem_rdata),
        .rsp_mem_wr_en(rsp_mem_wr_en), .rsp_mem_addr(rsp_mem_addr), .rsp_mem_wdata(rsp_mem_wdata),
        .verb_valid(verb_valid), .verb_ready(verb_ready), .verb_data(verb_data),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_cad(rsp_cad), .rsp_unsol(rsp_unsol),
        .rsp_irq(rsp_irq)
    );

    // Ring memory models and verb log.
    always @(posedge clk) begin
        if (cmd_mem_rd_en) begin
            if (cmd_mem_addr[1:0] != 2'b00 || cmd_mem_addr < CMD_BASE ||
                cmd_mem_addr >= CMD_BASE + 32'd1024) addr_err <= 1'b1;
            cmd_mem_rdata <= cmd_mem[8'((cmd_mem_addr - CMD_BASE) >> 2)];
        end
        if (rsp_mem_wr_en) begin
            rsp_mem[8'((rsp_mem_addr - RSP_BASE) >> 3)] <= rsp_mem_wdata;
            rsp_wr_cnt <= rsp_wr_cnt + 1;
        end
        if (verb_valid && verb_ready) vlog.push_back(verb_data);
    end

    function automatic logic [31:0] mkverb(input logic [7:0] i);
        return {i[3:0], 1'b0, i[6:0], 4'h0, i, 8'h5A};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_rsp(input logic [31:0] w, input logic [3:0] c, input logic u);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_word = w; rsp_cad = c; rsp_unsol = u;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd1, v); check("R1 cmd rp", v, 0);
        rd(4'd3, v); check("R1 rsp wp", v, 0);
        rd(4'd6, v); check("R1 rsp sts", v, 0);
        rd(4'd9, v); check("R1 imm sts", v, 0);
        check("R1 irq", rsp_irq, 0);
        check("R1 verb_valid", verb_valid, 0);
    endtask

    task automatic t_ring_order;
        logic [31:0] v;
        vlog.delete();
        wr(4'd2, 1); wr(4'd0, 3); idle(20);
        check("R3 count", vlog.size(), 3);
        for (int k = 0; k < 3; k++) check("R3 order", vlog[k], mkverb(8'(k + 1)));
        rd(4'd1, v); check("R3 rp", v, 3);
        check("R3 address", addr_err, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        vlog.delete();
        wr(4'd0, 255); idle(1100);
        wr(4'd0, 1); idle(30);
        check("R3 wrap count", vlog.size(), 254);
        check("R3 slot 255", vlog[251], mkverb(8'd255));
        check("R3 slot 0", vlog[252], mkverb(8'd0));
        check("R3 slot 1", vlog[253], mkverb(8'd1));
        rd(4'd1, v); check("R3 wrap rp", v, 1);
        check("R3 wrap address", addr_err, 0);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        vlog.delete();
        wr(4'd2, 0); wr(4'd0, 4); idle(20);
        check("R2 stopped no verb", vlog.size(), 0);
        rd(4'd1, v); check("R2 stopped rp", v, 1);
        wr(4'd2, 1); idle(20);
        check("R2 resume count", vlog.size(), 3);
        check("R2 resume first", vlog[0], mkverb(8'd2));
    endtask

    task automatic t_indirect_ring;
        logic [31:0] v;
        vlog.delete();
        cmd_mem[5] = mkverb(8'd5) | 32'h0800_0000;
        wr(4'd0, 6); idle(20);
        check("R4 one forwarded", vlog.size(), 1);
        check("R4 skip value", vlog[0], mkverb(8'd6));
        rd(4'd1, v); check("R4 rp past", v, 6);
    endtask

    task automatic t_hold;
        vlog.delete();
        verb_ready = 1'b0;
        wr(4'd0, 7); idle(10);
        check("R5 valid held", verb_valid, 1);
        check("R5 data", verb_data, mkverb(8'd7));
        idle(5);
        check("R5 data stable", verb_data, mkverb(8'd7));
        verb_ready = 1'b1; idle(5);
        check("R5 accepted once", vlog.size(), 1);
    endtask

    task automatic t_rsp_store;
        logic [31:0] v;
        wr(4'd2, 0); wr(4'd0, 9);
        wr(4'd4, 2); wr(4'd5, 3);
        send_rsp(32'hAAAA_0001, 4'h3, 1'b0);
        check("R8 entry solicited", rsp_mem[1], {32'h3, 32'hAAAA_0001});
        rd(4'd3, v); check("R8 wp", v, 1);
        check("R10 below threshold", rsp_irq, 0);
        send_rsp(32'hBBBB_0002, 4'hA, 1'b1);
        check("R8 entry unsolicited", rsp_mem[2], {32'h1A, 32'hBBBB_0002});
        check("R10 threshold irq", rsp_irq, 1);
        rd(4'd6, v); check("R10 sts", v, 1);
    endtask

    task automatic t_throttle;
        logic [31:0] v;
        vlog.delete();
        wr(4'd2, 1); idle(20);
        check("R2 throttled", vlog.size(), 0);
        wr(4'd6, 1); idle(20);
        rd(4'd6, v); check("R11 flag cleared", v, 0);
        check("R11 fetch resumed", vlog.size(), 2);
        rd(4'd1, v); check("R11 rp", v, 9);
    endtask

    task automatic t_empty_irq;
        send_rsp(32'h0000_00C1, 4'h1, 1'b0);
        check("R10 empty ring irq", rsp_irq, 1);
        wr(4'd6, 1);
        check("R11 clear", rsp_irq, 0);
        wr(4'd5, 2);
        send_rsp(32'h0000_00C2, 4'h1, 1'b0);
        check("R10 disabled irq", rsp_irq, 0);
        wr(4'd4, 255);
    endtask

    task automatic t_dma_off;
        logic [31:0] v0;
        logic [31:0] v1;
        int c0;
        wr(4'd5, 0);
        rd(4'd3, v0); c0 = rsp_wr_cnt;
        send_rsp(32'h0000_00D1, 4'h2, 1'b0);
        rd(4'd3, v1);
        check("R9 wp unchanged", v1, v0);
        check("R9 no write", rsp_wr_cnt, c0);
    endtask

    task automatic t_wp_clr;
        logic [31:0] v;
        wr(4'd5, 2);
        wr(4'd3, 32'h0000_8000);
        rd(4'd3, v); check("R12 wp cleared", v, 0);
        send_rsp(32'h0000_00E1, 4'h4, 1'b0);
        check("R12 slot 1 after clear", rsp_mem[1], {32'h4, 32'h0000_00E1});
    endtask

    task automatic t_imm;
        logic [31:0] v;
        logic [31:0] w0;
        int c0;
        vlog.delete();
        verb_ready = 1'b0;
        wr(4'd0, 11); idle(10);
        wr(4'd7, 32'h5123_4567);
        wr(4'd9, 1);
        rd(4'd9, v); check("R13 busy armed", v, 1);
        verb_ready = 1'b1; idle(20);
        check("R6 verb count", vlog.size(), 3);
        check("R6 ring first", vlog[0], mkverb(8'd10));
        check("R6 immediate next", vlog[1], 32'h5123_4567);
        check("R6 ring after", vlog[2], mkverb(8'd11));
        rd(4'd3, w0); c0 = rsp_wr_cnt;
        send_rsp(32'hBEEF_0042, 4'h5, 1'b0);
        rd(4'd8, v); check("R7 imm reply", v, 32'hBEEF_0042);
        rd(4'd9, v); check("R7 imm status", v, 32'h52);
        rd(4'd3, v); check("R7 no ring wp", v, w0);
        check("R7 no ring write", rsp_wr_cnt, c0);
        wr(4'd9, 2);
        rd(4'd9, v); check("R13 valid cleared", v, 32'h50);
    endtask

    task automatic t_imm_indirect;
        logic [31:0] v;
        vlog.delete();
        wr(4'd7, 32'h5800_0000);
        wr(4'd9, 1); idle(20);
        check("R4 imm indirect dropped", vlog.size(), 0);
        rd(4'd9, v); check("R4 busy stays", v, 32'h51);
        send_rsp(32'h0000_1234, 4'h2, 1'b0);
        rd(4'd9, v); check("R7 second capture", v, 32'h22);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            cmd_mem[i] = mkverb(8'(i));
            rsp_mem[i] = '0;
        end
        idle(5);
        rst_n = 1'b1;
        t_reset();
        wr(4'd4, 255); wr(4'd5, 2);
        t_ring_order();
        t_wrap();
        t_stop();
        t_indirect_ring();
        t_hold();
        t_rsp_store();
        t_throttle();
        t_empty_irq();
        t_dma_off();
        t_wp_clr();
        t_imm();
        t_imm_indirect();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule